// File: doc/BRIEF.md
# Dual-Queue Scan Trigger Controller

This block decides when each of two conversion queues begins a pass and how that pass runs. Each queue has a 3-bit operating mode and an arm bit, which software sets through a per-queue write strobe. Once a queue is armed in a live single-scan mode, a mode-specific event starts it. The event is the arming itself, a synchronized rising edge on an external trigger, a synchronized gate level, or an interval-timer tick. While a queue runs, it issues one start-conversion strobe per cycle. It stops after a fixed list length, and on completion it raises a sticky done flag and disarms itself.

Only one queue converts at a time, and queue 1 wins when both are ready. The block also reports when both queues are effectively disabled. The surrounding logic uses this signal to serve RAM accesses without wait states and to permit a clock prescaler update.

Top module: `dual_queue_scan_ctrl`

## Requirements
- R1: Mode code 000 is disabled. A queue in this mode never becomes active, never strobes, and does not accept the arm bit, whatever its triggers do.
- R2: Mode codes 101, 110 and 111 behave exactly like 000.
- R3: `all_off_o` is 1 exactly when neither queue is in a live mode. No queue is active while it is 1.
- R4: Code 011 (gated) on queue 2 (index 1) is treated as disabled. Its gate input does not start queue 2, and the queue counts as off for R3.
- R5: A queue in a live mode ignores its trigger events while its arm bit is clear. The arm bit may be set in the same write that selects the mode.
- R6: Read data is {arm, mode[2:0]} for the queue chosen by `rd_sel_i`, and bit 3 always reads 0. Writing the arm bit as 0 leaves an armed queue armed.
- R7: Mode 001 (software) starts the queue because it is armed. No further event is needed.
- R8: Mode 010 (external trigger) starts on a rising edge of `ext_trig_i`, seen through a two-flop synchronizer.
- R9: Mode 011 on queue 1 starts when the synchronized gate is high. Strobes pause while the gate is low and resume when it returns high.
- R10: Mode 100 (interval) starts on a one-cycle pulse of `tick_i`.
- R11: A run gives exactly LIST_LEN start strobes. `active_o` is high during the run. At the end, `done_o` is set, the queue disarms, and later triggers are ignored until the queue is armed again.
- R12: `done_o` stays set until a 1 is written to `flag_clr_i` for that queue.
- R13: Queue 1 has priority when both queues become ready together. Queue 2 then waits until queue 1 completes, and the two queues never strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 2 | Per-queue control write strobe |
| cfg_mode_i | input | 3 | Mode write data |
| cfg_arm_i | input | 1 | Arm bit write data (set-only) |
| flag_clr_i | input | 2 | Write-1-to-clear of done flags |
| rd_sel_i | input | 1 | Queue selected for readback |
| rd_data_o | output | 4 | {arm (reads 0), mode} |
| ext_trig_i | input | 2 | Asynchronous external triggers |
| ext_gate_i | input | 1 | Asynchronous gate level, queue 1 only |
| tick_i | input | 2 | Interval-timer ticks |
| active_o | output | 2 | Queue running |
| start_o | output | 2 | Start-conversion strobe |
| done_o | output | 2 | Sticky completion flags |
| all_off_o | output | 1 | Both queues disabled |

## Verification
The bench aims at the disguised disabled codes: the reserved values, and the gated code written to queue 2. A design that decoded these too loosely would run a queue or drop `all_off_o`. The bench also tests a write of 0 to the arm bit and a second trigger after completion. A design that cleared the arm on a zero write would miss the trigger, and one that stayed armed after a run would start again. A gate drop in the middle of a run must freeze the strobe count without losing the run. The bench also arms both queues in the same cycle and checks that queue 2 never strobes before queue 1 has finished its list.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [2:0] {
    MODE_OFF  = 3'b000,
    MODE_SW   = 3'b001,
    MODE_EXT  = 3'b010,
    MODE_GATE = 3'b011,
    MODE_TICK = 3'b100
  } scan_mode_e;

  // codes 101..111 and forbidden gated fall through as not live
  function automatic logic mode_live(input logic [2:0] m, input logic allow_gated);
    return (m == MODE_SW) || (m == MODE_EXT) || (m == MODE_TICK) ||
           ((m == MODE_GATE) && allow_gated);
  endfunction
endpackage

// File: rtl/scan_sync.sv
module scan_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sr_q   <= {sr_q[STAGES-2:0], d_i};
      prev_q <= sr_q[STAGES-1];
    end
  end

  assign level_o = sr_q[STAGES-1];
  assign rise_o  = sr_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/queue_seq.sv
module queue_seq
  import scan_pkg::*;
#(
  parameter int   LIST_LEN    = 4,
  parameter logic ALLOW_GATED = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic [2:0] cfg_mode_i,
  input  logic       cfg_arm_i,
  input  logic       flag_clr_i,
  input  logic       ext_trig_i,
  input  logic       ext_gate_i,
  input  logic       tick_i,
  input  logic       grant_i,
  output logic       req_o,
  output logic       run_o,
  output logic       start_o,
  output logic       done_o,
  output logic [2:0] mode_o,
  output logic       off_o
);
  localparam int CNT_W = (LIST_LEN > 1) ? $clog2(LIST_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LIST_LEN - 1);

  logic [2:0]       mode_q;
  logic             arm_q, req_q, run_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic             trig_rise, gate_lvl, live_q, wr_live, gated_mode;
  logic             trig_ev, conv_en, last;

  scan_sync #(.STAGES(2)) u_trig_sync (
    .clk_i, .rst_ni, .d_i(ext_trig_i), .level_o(), .rise_o(trig_rise)
  );

  generate
    if (ALLOW_GATED) begin : g_gate
      scan_sync #(.STAGES(2)) u_gate_sync (
        .clk_i, .rst_ni, .d_i(ext_gate_i), .level_o(gate_lvl), .rise_o()
      );
    end else begin : g_nogate
      logic unused_gate;
      assign unused_gate = ext_gate_i;
      assign gate_lvl    = 1'b0;
    end
  endgenerate

  assign live_q     = mode_live(mode_q, ALLOW_GATED);
  assign wr_live    = mode_live(cfg_mode_i, ALLOW_GATED);
  assign gated_mode = ALLOW_GATED && (mode_q == MODE_GATE);

  always_comb begin
    unique case (mode_q)
      MODE_SW:   trig_ev = 1'b1;
      MODE_EXT:  trig_ev = trig_rise;
      MODE_GATE: trig_ev = gate_lvl;
      MODE_TICK: trig_ev = tick_i;
      default:   trig_ev = 1'b0;
    endcase
    trig_ev = trig_ev & live_q & arm_q & ~req_q & ~run_q;
  end

  assign conv_en = run_q & (~gated_mode | gate_lvl);
  assign last    = conv_en & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      arm_q  <= 1'b0;
      req_q  <= 1'b0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (trig_ev) req_q <= 1'b1;
      if (grant_i) begin
        req_q <= 1'b0;
        run_q <= 1'b1;
        cnt_q <= CNT_TOP;
      end
      if (conv_en) cnt_q <= cnt_q - 1'b1;
      if (flag_clr_i) done_q <= 1'b0;
      if (last) begin
        run_q  <= 1'b0;
        arm_q  <= 1'b0;
        done_q <= 1'b1;
      end
      if (cfg_we_i) begin
        mode_q <= cfg_mode_i;
        if (!wr_live) begin
          arm_q <= 1'b0;
          req_q <= 1'b0;
          run_q <= 1'b0;
        end else if (cfg_arm_i) begin
          arm_q <= 1'b1; // set-only
        end
      end
    end
  end

  assign req_o   = req_q;
  assign run_o   = run_q;
  assign start_o = conv_en;
  assign done_o  = done_q;
  assign mode_o  = mode_q;
  assign off_o   = ~live_q;

  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live_q |-> (!run_q && !arm_q && !req_q)); // R1
  AST_RUN_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> arm_q); // R5
  AST_DONE_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> !run_q); // R11
  AST_GATE_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && gated_mode && !gate_lvl) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/dual_queue_scan_ctrl.sv
module dual_queue_scan_ctrl #(
  parameter int LIST_LEN = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cfg_we_i,
  input  logic [2:0] cfg_mode_i,
  input  logic       cfg_arm_i,
  input  logic [1:0] flag_clr_i,
  input  logic       rd_sel_i,
  output logic [3:0] rd_data_o,
  input  logic [1:0] ext_trig_i,
  input  logic       ext_gate_i,
  input  logic [1:0] tick_i,
  output logic [1:0] active_o,
  output logic [1:0] start_o,
  output logic [1:0] done_o,
  output logic       all_off_o
);
  localparam int NQ = 2;

  logic [NQ-1:0] req, run, grant, off;
  logic [2:0]    mode [NQ];
  logic          busy;

  assign busy     = |run;
  assign grant[0] = req[0] & ~busy;
  assign grant[1] = req[1] & ~busy & ~req[0];

  for (genvar g = 0; g < NQ; g++) begin : g_q
    queue_seq #(
      .LIST_LEN   (LIST_LEN),
      .ALLOW_GATED(g == 0)
    ) u_seq (
      .clk_i,
      .rst_ni,
      .cfg_we_i  (cfg_we_i[g]),
      .cfg_mode_i,
      .cfg_arm_i,
      .flag_clr_i(flag_clr_i[g]),
      .ext_trig_i(ext_trig_i[g]),
      .ext_gate_i((g == 0) ? ext_gate_i : 1'b0),
      .tick_i    (tick_i[g]),
      .grant_i   (grant[g]),
      .req_o     (req[g]),
      .run_o     (run[g]),
      .start_o   (start_o[g]),
      .done_o    (done_o[g]),
      .mode_o    (mode[g]),
      .off_o     (off[g])
    );
  end

  assign active_o  = run;
  assign all_off_o = &off;
  assign rd_data_o = {1'b0, mode[rd_sel_i]};

  AST_SINGLE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(run) <= 1); // R13
  AST_Q1_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req[0] && req[1]) |=> !run[1]); // R13
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_off_o |-> (run == '0)); // R3
  AST_NO_DUAL_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o[0] && start_o[1])); // R13
endmodule

// File: tb/dual_queue_scan_ctrl_bench.sv
module dual_queue_scan_ctrl_bench;
  localparam int LEN = 8;
  localparam int NV  = 10;
  // stimulus: 0 none, 1 ext pulse, 2 tick, 3 gate high
  localparam int V_Q   [NV] = '{0, 0, 0, 0, 0, 1, 0, 1, 1, 1};
  localparam int V_MODE[NV] = '{1, 0, 6, 2, 4, 3, 3, 2, 4, 1};
  localparam int V_ARM [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 1, 1};
  localparam int V_STIM[NV] = '{0, 1, 0, 1, 2, 3, 3, 1, 2, 0};
  localparam int V_NST [NV] = '{LEN, 0, 0, LEN, LEN, 0, LEN, 0, LEN, LEN};
  localparam int V_DONE[NV] = '{1, 0, 0, 1, 1, 0, 1, 0, 1, 1};
  localparam string V_TAG[NV] = '{"R7", "R1", "R2", "R8", "R10", "R4", "R9", "R5", "R10", "R7"};

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] cfg_we_i = '0;
  logic [2:0] cfg_mode_i = '0;
  logic       cfg_arm_i = 1'b0;
  logic [1:0] flag_clr_i = '0;
  logic       rd_sel_i = 1'b0;
  logic [3:0] rd_data_o;
  logic [1:0] ext_trig_i = '0;
  logic       ext_gate_i = 1'b0;
  logic [1:0] tick_i = '0;
  logic [1:0] active_o, start_o, done_o;
  logic       all_off_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #10 clk_i = ~clk_i;

  dual_queue_scan_ctrl #(.LIST_LEN(LEN)) u_dual_queue_scan_ctrl (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] mask, input int mode, input bit arm);
    @(negedge clk_i);
    cfg_we_i   = mask;
    cfg_mode_i = 3'(mode);
    cfg_arm_i  = arm;
    @(negedge clk_i);
    cfg_we_i   = '0;
    cfg_arm_i  = 1'b0;
  endtask

  task automatic clr(input logic [1:0] mask);
    @(negedge clk_i);
    flag_clr_i = mask;
    @(negedge clk_i);
    flag_clr_i = '0;
  endtask

  // counts strobes on queue q; drives stimulus at step 3
  task automatic count_run(input int q, input int stim, input int cycles, output int n);
    n = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk_i);
      if (start_o[q]) n++;
      if (c == 3) begin
        if (stim == 1) ext_trig_i[q] = 1'b1;
        if (stim == 2) tick_i[q] = 1'b1;
        if (stim == 3) ext_gate_i = 1'b1;
      end
      if (c == 4) tick_i = '0;
      if (c == 7) ext_trig_i = '0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!ended) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, m, both, early, n0, n1;
    repeat (3) @(negedge clk_i);
    // reset state
    chk("R3 reset all_off", all_off_o, 1);
    chk("R11 reset active", active_o, 0);
    chk("R12 reset done", done_o, 0);
    chk("R11 reset start", start_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table walk
    for (int v = 0; v < NV; v++) begin
      wr(2'(1 << V_Q[v]), V_MODE[v], V_ARM[v] != 0);
      count_run(V_Q[v], V_STIM[v], 30, n);
      chk({V_TAG[v], " strobes"}, n, V_NST[v]);
      chk({V_TAG[v], " done"}, done_o[V_Q[v]], V_DONE[v]);
      chk({V_TAG[v], " idle after"}, active_o[V_Q[v]], 0);
      ext_gate_i = 1'b0;
      clr(2'b11);
      wr(2'b11, 0, 1'b0);
    end

    // R4/R2/R3: all_off decoding
    wr(2'b10, 3, 1'b0);
    chk("R4 q2 gated is off", all_off_o, 1);
    wr(2'b01, 5, 1'b0);
    chk("R2 reserved is off", all_off_o, 1);
    wr(2'b01, 2, 1'b0);
    chk("R3 live mode drops all_off", all_off_o, 0);
    wr(2'b11, 0, 1'b0);
    chk("R3 both off", all_off_o, 1);

    // R6: readback and zero write
    wr(2'b01, 2, 1'b1);
    rd_sel_i = 1'b0;
    #1;
    chk("R6 readback arm zero", rd_data_o, 4'b0010);
    wr(2'b01, 2, 1'b0);
    count_run(0, 1, 30, n);
    chk("R6 zero write keeps arm", n, LEN);
    chk("R12 done sticky", done_o[0], 1);
    repeat (3) @(negedge clk_i);
    chk("R12 done still set", done_o[0], 1);
    clr(2'b01);
    chk("R12 done cleared", done_o[0], 0);
    count_run(0, 1, 30, n);
    chk("R11 no rerun without arm", n, 0);
    chk("R11 no done without arm", done_o[0], 0);
    wr(2'b11, 0, 1'b0);

    // R9: gate pause mid-run
    wr(2'b01, 3, 1'b1);
    ext_gate_i = 1'b1;
    n = 0;
    for (int c = 0; c < 20 && n < 2; c++) begin
      @(negedge clk_i);
      if (start_o[0]) n++;
    end
    ext_gate_i = 1'b0;
    repeat (3) begin
      @(negedge clk_i);
      if (start_o[0]) n++;
    end
    m = 0;
    repeat (6) begin
      @(negedge clk_i);
      if (start_o[0]) m++;
    end
    chk("R9 paused strobes", m, 0);
    chk("R9 still active in pause", active_o[0], 1);
    ext_gate_i = 1'b1;
    repeat (20) begin
      @(negedge clk_i);
      if (start_o[0]) n++;
    end
    chk("R9 total after resume", n, LEN);
    chk("R9 done", done_o[0], 1);
    ext_gate_i = 1'b0;
    clr(2'b11);
    wr(2'b11, 0, 1'b0);

    // R13: simultaneous arming
    wr(2'b11, 1, 1'b1);
    n0 = 0; n1 = 0; both = 0; early = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk_i);
      if (start_o[0] && start_o[1]) both++;
      if (start_o[1] && n0 < LEN) early++;
      if (start_o[0]) n0++;
      if (start_o[1]) n1++;
    end
    chk("R13 q1 strobes", n0, LEN);
    chk("R13 q2 strobes", n1, LEN);
    chk("R13 no dual strobe", both, 0);
    chk("R13 q2 waits for q1", early, 0);
    chk("R13 both done", done_o, 2'b11);

    ended = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule